// File: doc/BRIEF.md
# UART Automatic Flow Control

This block sits beside one UART channel, between the receive deserializer, the transmit serializer and the receive FIFO. It decides when the transmitter may start another character. The transmitter is stopped in two cases: when the far end drops its clear-to-send line, which is active low, or when the far end sends a programmed "stop" character. A programmed "go" character releases the transmitter again. The stop always takes effect on a character boundary. A character that is already on the wire is finished, up to its stop bit, before the transmit permission is withdrawn.

On the receive side, every character passes through the block before it reaches the FIFO. Characters that match the active flow-control pattern are consumed and never written. All other characters are written one cycle later. A special-character option writes a match against the second stop character and flags it. The block also drives the local request-to-send line, which is active low, from the receive FIFO fill level so that the far end pauses before the FIFO overflows.

A configuration byte selects the features. Bit 7 enables automatic clear-to-send, bit 6 enables automatic request-to-send and bit 5 enables special-character detect. Bits [1:0] select the flow-character mode: 0 off, 1 single characters from pair 1, 2 single characters from pair 2, 3 two-character sequences. Bits 4 to 2 are ignored. The pattern registers line up bit for bit with the received character, bit 0 against the least significant data bit. Received characters must be at least two cycles apart.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset `tx_allow` is 1, `rts_n` is 0, and `fifo_wr`, `spec_hit` and `cts_evt` are 0. The software stall flag is clear.
- R2: With bit 7 set and the transmitter idle, `tx_allow` falls two cycles after `cts_n` goes high and rises two cycles after `cts_n` goes low. With bit 7 clear, `cts_n` has no effect on `tx_allow`.
- R3: While `tx_idle` is 0, a stall request leaves `tx_allow` at 1 until the cycle after a `tx_char_done` pulse, which marks that the stop bit has been sent.
- R4: With bit 7 set, a low-to-high change of `cts_n` produces a one-cycle `cts_evt` pulse, two cycles after the change.
- R5: With bit 6 set, `rts_n` is 1 one cycle after `rx_count >= rx_trig` and 0 one cycle after `rx_count < rx_trig`. With bit 6 clear, `rts_n` stays 0.
- R6: A character that is not consumed appears on `fifo_data` with `fifo_wr` high one cycle after its `rx_valid`, and characters are written in arrival order.
- R7: In mode 1, a character equal to `xon1` or `xoff1` is consumed. In mode 2, a character equal to `xon2` or `xoff2` is consumed. A consumed stop character sets the stall, so an idle transmitter sees `tx_allow` fall three cycles after the character. A consumed go character clears the stall.
- R8: In mode 3, `xon1` followed directly by `xon2` is consumed as a go, and `xoff1` followed directly by `xoff2` is consumed as a stop.
- R9: In mode 3, a held `xon1` or `xoff1` that is not completed by the next character is written one cycle after that character arrives. The next character is then handled one cycle later.
- R10: With bit 5 set, a character equal to `xoff2` is always written, with `spec_hit` high in the same cycle. This check takes priority over flow matching.
- R11: In mode 0, all characters are written and the software stall is cleared, so `tx_allow` recovers two cycles after the mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat | input | 8 | Feature configuration byte |
| xon1 | input | 8 | First go pattern |
| xon2 | input | 8 | Second go pattern |
| xoff1 | input | 8 | First stop pattern |
| xoff2 | input | 8 | Second stop pattern, also the special character |
| rx_char | input | 8 | Received character |
| rx_valid | input | 1 | Received character strobe |
| tx_idle | input | 1 | Serializer has no character in flight |
| tx_char_done | input | 1 | Stop bit of the current character has been sent |
| cts_n | input | 1 | Clear-to-send from far end, active low |
| rx_count | input | 6 | Receive FIFO fill level |
| rx_trig | input | 6 | Receive trigger level |
| tx_allow | output | 1 | Serializer may start a new character |
| rts_n | output | 1 | Request-to-send, active low |
| cts_evt | output | 1 | Pulse when the far end stops clearing transmission |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_data | output | 8 | Receive FIFO write data |
| spec_hit | output | 1 | Written character matched the special pattern |

## Verification
Each result has a fixed latency from its stimulus. Writes and `spec_hit` follow `rx_valid` by one cycle. `rts_n` follows `rx_count` by one cycle. `tx_allow` and `cts_evt` follow `cts_n` by two cycles, and `tx_allow` follows a consumed stop character by three cycles. The bench drives inputs on falling edges and checks the precise edges on falling edges too. For CTS, RTS and the boundary case it checks both the cycle before the change and the cycle of the change. A scoreboard queue holds the expected writes, and a falling-edge monitor compares them in order, which covers the deferred write of a broken sequence.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
  localparam int unsigned FB_AUTO_CTS = 7;
  localparam int unsigned FB_AUTO_RTS = 6;
  localparam int unsigned FB_SPECIAL  = 5;

  typedef enum logic [1:0] {
    FM_OFF   = 2'd0,
    FM_PAIR1 = 2'd1,
    FM_PAIR2 = 2'd2,
    FM_SEQ   = 2'd3
  } flow_mode_e;
endpackage

// File: rtl/ufc_char_match.sv
module ufc_char_match
  import ufc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  flow_mode_e    mode,
  input  logic          spec_en,
  input  logic [DW-1:0] xon1,
  input  logic [DW-1:0] xon2,
  input  logic [DW-1:0] xoff1,
  input  logic [DW-1:0] xoff2,
  input  logic [DW-1:0] rx_char,
  input  logic          rx_valid,
  output logic          fifo_wr,
  output logic [DW-1:0] fifo_data,
  output logic          spec_hit,
  output logic          on_hit,
  output logic          off_hit
);
  logic [DW-1:0] held_q, defer_q;
  logic          held_v, defer_v;

  logic          eff_v;
  logic [DW-1:0] cur;
  logic          is_spec;

  assign eff_v   = rx_valid | defer_v;
  assign cur     = defer_v ? defer_q : rx_char;
  assign is_spec = spec_en && (cur == xoff2);

  logic          wr_n, spec_n, on_n, off_n, hold_set, hold_clr, defer_set;
  logic [DW-1:0] data_n;

  always_comb begin
    wr_n      = 1'b0;
    data_n    = cur;
    spec_n    = 1'b0;
    on_n      = 1'b0;
    off_n     = 1'b0;
    hold_set  = 1'b0;
    hold_clr  = 1'b0;
    defer_set = 1'b0;
    if (eff_v) begin
      if (held_v) begin
        hold_clr = 1'b1;
        if (!is_spec && held_q == xon1 && cur == xon2) begin
          on_n = 1'b1;
        end else if (!is_spec && held_q == xoff1 && cur == xoff2) begin
          off_n = 1'b1;
        end else begin
          wr_n      = 1'b1;
          data_n    = held_q;
          defer_set = 1'b1;
        end
      end else if (is_spec) begin
        wr_n   = 1'b1;
        spec_n = 1'b1;
      end else begin
        unique case (mode)
          FM_PAIR1: begin
            if (cur == xon1)       on_n  = 1'b1;
            else if (cur == xoff1) off_n = 1'b1;
            else                   wr_n  = 1'b1;
          end
          FM_PAIR2: begin
            if (cur == xon2)       on_n  = 1'b1;
            else if (cur == xoff2) off_n = 1'b1;
            else                   wr_n  = 1'b1;
          end
          FM_SEQ: begin
            if (cur == xon1 || cur == xoff1) hold_set = 1'b1;
            else                             wr_n     = 1'b1;
          end
          default: wr_n = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_v    <= 1'b0;
      held_q    <= '0;
      defer_v   <= 1'b0;
      defer_q   <= '0;
      fifo_wr   <= 1'b0;
      fifo_data <= '0;
      spec_hit  <= 1'b0;
      on_hit    <= 1'b0;
      off_hit   <= 1'b0;
    end else begin
      fifo_wr  <= wr_n;
      spec_hit <= spec_n;
      on_hit   <= on_n;
      off_hit  <= off_n;
      if (wr_n) fifo_data <= data_n;
      defer_v <= defer_set;
      if (defer_set) defer_q <= cur;
      if (hold_set) begin
        held_v <= 1'b1;
        held_q <= cur;
      end else if (hold_clr) begin
        held_v <= 1'b0;
      end
    end
  end

  // R10: a special flag only ever comes with a write
  p_spec_with_write_r10: assert property (@(posedge clk) disable iff (rst)
    spec_hit |-> fifo_wr);
  // R6: every write is due to a character presented one cycle earlier
  p_write_has_source_r6: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> ($past(rx_valid) || $past(defer_v)));
  // R7: flow hits only arise while a flow mode was active
  p_hit_needs_mode_r7: assert property (@(posedge clk) disable iff (rst)
    (on_hit || off_hit) |-> ($past(mode) != FM_OFF));
endmodule

// File: rtl/ufc_tx_gate.sv
module ufc_tx_gate
  import ufc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       auto_cts,
  input  flow_mode_e mode,
  input  logic       on_hit,
  input  logic       off_hit,
  input  logic       cts_n,
  input  logic       tx_idle,
  input  logic       tx_char_done,
  output logic       tx_allow,
  output logic       cts_evt
);
  logic cts_q, cts_d, sw_stall, stall;

  assign stall = (auto_cts & cts_q) | sw_stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      cts_q    <= 1'b0;
      cts_d    <= 1'b0;
      cts_evt  <= 1'b0;
      sw_stall <= 1'b0;
      tx_allow <= 1'b1;
    end else begin
      cts_q   <= cts_n;
      cts_d   <= cts_q;
      cts_evt <= auto_cts & cts_q & ~cts_d;
      if (mode == FM_OFF)  sw_stall <= 1'b0;
      else if (off_hit)    sw_stall <= 1'b1;
      else if (on_hit)     sw_stall <= 1'b0;
      if (!stall)                       tx_allow <= 1'b1;
      else if (tx_idle || tx_char_done) tx_allow <= 1'b0;
    end
  end

  // R3: mid-character, permission is never withdrawn
  p_hold_midchar_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_allow && !tx_idle && !tx_char_done) |=> tx_allow);
  // R4: the CTS event is a single-cycle pulse
  p_cts_evt_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    cts_evt |=> !cts_evt);
  // R2: permission returns only once no stall source remains
  p_allow_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_allow) |-> !$past(stall));
endmodule

// File: rtl/ufc_rts_ctrl.sv
module ufc_rts_ctrl #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          auto_rts,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] rx_trig,
  output logic          rts_n
);
  always_ff @(posedge clk) begin
    if (rst) rts_n <= 1'b0;
    else     rts_n <= auto_rts && (rx_count >= rx_trig);
  end

  // R5: without automatic RTS the line stays asserted
  p_rts_manual_r5: assert property (@(posedge clk) disable iff (rst)
    !auto_rts |=> !rts_n);
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import ufc_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned FIFO_DEPTH = 32,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    feat,
  input  logic [DW-1:0] xon1,
  input  logic [DW-1:0] xon2,
  input  logic [DW-1:0] xoff1,
  input  logic [DW-1:0] xoff2,
  input  logic [DW-1:0] rx_char,
  input  logic          rx_valid,
  input  logic          tx_idle,
  input  logic          tx_char_done,
  input  logic          cts_n,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] rx_trig,
  output logic          tx_allow,
  output logic          rts_n,
  output logic          cts_evt,
  output logic          fifo_wr,
  output logic [DW-1:0] fifo_data,
  output logic          spec_hit
);
  flow_mode_e mode;
  logic       on_hit, off_hit;

  assign mode = flow_mode_e'(feat[1:0]);

  ufc_char_match #(.DW(DW)) u_match (
    .clk(clk), .rst(rst), .mode(mode), .spec_en(feat[FB_SPECIAL]),
    .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2),
    .rx_char(rx_char), .rx_valid(rx_valid),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .spec_hit(spec_hit),
    .on_hit(on_hit), .off_hit(off_hit)
  );

  ufc_tx_gate u_gate (
    .clk(clk), .rst(rst), .auto_cts(feat[FB_AUTO_CTS]), .mode(mode),
    .on_hit(on_hit), .off_hit(off_hit), .cts_n(cts_n),
    .tx_idle(tx_idle), .tx_char_done(tx_char_done),
    .tx_allow(tx_allow), .cts_evt(cts_evt)
  );

  ufc_rts_ctrl #(.CW(CW)) u_rts (
    .clk(clk), .rst(rst), .auto_rts(feat[FB_AUTO_RTS]),
    .rx_count(rx_count), .rx_trig(rx_trig), .rts_n(rts_n)
  );

  // R1: reset leaves transmission permitted and RTS asserted
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (tx_allow && !rts_n && !fifo_wr && !cts_evt));
endmodule

// File: tb/uart_flow_ctrl_tb_top.sv
module uart_flow_ctrl_tb_top;
  localparam logic [7:0] XON1 = 8'h11, XOFF1 = 8'h13, XON2 = 8'h21, XOFF2 = 8'h23;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] feat = '0;
  logic [7:0] rx_char = '0;
  logic       rx_valid = 1'b0, tx_idle = 1'b1, tx_char_done = 1'b0, cts_n = 1'b0;
  logic [5:0] rx_count = '0, rx_trig = 6'd16;
  logic       tx_allow, rts_n, cts_evt, fifo_wr, spec_hit;
  logic [7:0] fifo_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [8:0] exp_q[$];

  always #2.5 clk = ~clk;

  uart_flow_ctrl dut_i (
    .clk(clk), .rst(rst), .feat(feat), .xon1(XON1), .xon2(XON2),
    .xoff1(XOFF1), .xoff2(XOFF2), .rx_char(rx_char), .rx_valid(rx_valid),
    .tx_idle(tx_idle), .tx_char_done(tx_char_done), .cts_n(cts_n),
    .rx_count(rx_count), .rx_trig(rx_trig), .tx_allow(tx_allow),
    .rts_n(rts_n), .cts_evt(cts_evt), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data), .spec_hit(spec_hit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c, input bit store, input bit spec);
    if (store) exp_q.push_back({spec, c});
    rx_char  = c;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor (R6, R9, R10 ordering and content)
  always @(negedge clk) begin
    if (!rst && fifo_wr) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R6: actual write %0h expected none", fifo_data);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk("R6/R10 write", {spec_hit, fifo_data}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 tx_allow", tx_allow, 1);
    chk("R1 rts_n", rts_n, 0);
    chk("R1 fifo_wr", fifo_wr, 0);
    chk("R1 cts_evt", cts_evt, 0);

    // R11 mode off: everything stored
    send(8'h41, 1, 0);
    send(XOFF1, 1, 0);
    chk("R11 no stall", tx_allow, 1);

    // R7 mode 1
    feat = 8'h01;
    send(8'h55, 1, 0);
    send(XOFF1, 0, 0);
    chk("R7 xoff1 stalls", tx_allow, 0);
    send(XON1, 0, 0);
    chk("R7 xon1 resumes", tx_allow, 1);

    // R7 mode 2
    feat = 8'h02;
    send(XOFF2, 0, 0);
    chk("R7 xoff2 stalls", tx_allow, 0);
    send(XON1, 1, 0);
    send(XON2, 0, 0);
    chk("R7 xon2 resumes", tx_allow, 1);

    // R11 leaving flow mode clears stall
    feat = 8'h01;
    send(XOFF1, 0, 0);
    chk("R11 pre", tx_allow, 0);
    feat = 8'h00;
    @(negedge clk);
    chk("R11 one cycle", tx_allow, 0);
    @(negedge clk);
    chk("R11 two cycles", tx_allow, 1);

    // R9 / R8 sequence mode
    feat = 8'h03;
    send(XON1, 0, 0);
    exp_q.push_back({1'b0, XON1});
    send(8'h41, 1, 0);
    chk("R9 queue drained", exp_q.size(), 0);
    send(XOFF1, 0, 0);
    send(XOFF2, 0, 0);
    chk("R8 seq stop", tx_allow, 0);
    send(XON1, 0, 0);
    send(XON2, 0, 0);
    chk("R8 seq go", tx_allow, 1);

    // R10 special detect
    feat = 8'h21;
    send(XOFF2, 1, 1);
    send(XOFF1, 0, 0);
    chk("R10 flow still works", tx_allow, 0);
    send(XON1, 0, 0);
    chk("R10 resume", tx_allow, 1);

    // R2 / R4 auto CTS, idle transmitter
    feat = 8'h80;
    cts_n = 1'b1;
    @(negedge clk);
    chk("R2 allow +1", tx_allow, 1);
    chk("R4 evt +1", cts_evt, 0);
    @(negedge clk);
    chk("R2 allow +2", tx_allow, 0);
    chk("R4 evt +2", cts_evt, 1);
    @(negedge clk);
    chk("R4 evt +3", cts_evt, 0);
    cts_n = 1'b0;
    @(negedge clk);
    chk("R2 release +1", tx_allow, 0);
    @(negedge clk);
    chk("R2 release +2", tx_allow, 1);

    feat = 8'h00;
    cts_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 ignored", tx_allow, 1);
    chk("R4 no evt", cts_evt, 0);
    cts_n = 1'b0;
    repeat (2) @(negedge clk);

    // R3 boundary wait
    feat = 8'h80;
    tx_idle = 1'b0;
    cts_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 mid-char", tx_allow, 1);
    tx_char_done = 1'b1;
    @(negedge clk);
    tx_char_done = 1'b0;
    chk("R3 after stop bit", tx_allow, 0);
    cts_n = 1'b0;
    tx_idle = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 recover", tx_allow, 1);

    // R5 auto RTS
    feat = 8'h40;
    rx_count = 6'd15;
    repeat (2) @(negedge clk);
    chk("R5 below", rts_n, 0);
    rx_count = 6'd16;
    @(negedge clk);
    chk("R5 at trigger", rts_n, 1);
    rx_count = 6'd15;
    @(negedge clk);
    chk("R5 below again", rts_n, 0);
    feat = 8'h00;
    rx_count = 6'd30;
    repeat (2) @(negedge clk);
    chk("R5 disabled", rts_n, 0);

    repeat (3) @(negedge clk);
    chk("R6 queue empty", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule